// File: doc/BRIEF.md
# Multi-Source Interrupt Pending and Priority Selector

This block holds the pending-interrupt state of one processor core and chooses the single interrupt to deliver next. There are seven sources, and each has its own 64-bit pending vector. A post request names a source type and a bit index and sets that bit. A clear request names a type and an index and removes that bit. Alongside the vectors the block keeps a one-bit-per-type summary, and selection reads from this summary.

The choice follows a fixed priority ladder, and the ladder depends on two core flags: a hyperprivileged-mode flag and an interrupt-enable flag. The result is registered and presented as a valid flag, a 3-bit source code and a 4-bit level. The level is non-zero only when the winner is the software interrupt. It is then found by scanning the software-interrupt vector downward, with a special case checked before the scan. A request whose type code names no source is dropped, and it raises a one-cycle error strobe.

Top module: `irq_pend_sel`

## Requirements
- R1: While reset (active low) is asserted, and on the first cycle after it is released, all vectors and summary bits are zero, and intValid, intCode, intLevel and errStrobe are all 0.
- R2: A post of type t (0 to 6) and index i (0 to 63) sets bit i of vector t. It also sets pendSummary[t], which is visible one cycle after the request. The selection outputs reflect the new summary one cycle after that.
- R3: A clear of type t and index i removes bit i of vector t. pendSummary[t] drops only when vector t is all zero after the clear. While another bit of vector t is still set, pendSummary[t] stays 1.
- R4: If a post and a clear in the same cycle target the same type and index, that bit ends up cleared. If they target different bits, both take effect.
- R5: A post or clear whose type code is 7 changes no vector and no summary bit. errStrobe is 1 for exactly the one cycle after such a request.
- R6: With hprivMode=1, only two sources are eligible. Code 0 (timer match) wins over code 1 (interrupt vector). intEnable has no effect in this mode.
- R7: With hprivMode=0, the order is code 2 (trap level zero), then code 0, then code 1. This holds whatever the value of intEnable.
- R8: With hprivMode=0 and intEnable=1, the sources after those of R7 are, in order: code 3 (CPU mondo), code 4 (device mondo), code 5 (software interrupt), code 6 (resumable error). With intEnable=0, codes 3 to 6 are never selected.
- R9: When the winner is code 5, intLevel is chosen from the software vector as follows. If bit 0 or bit 16 is set, intLevel is 14. Otherwise intLevel is the highest set bit in the range 15 down to 1. If none of bits 15 to 1 is set, intLevel is 1. For any other winner, intLevel is 0.
- R10: When no eligible source is pending, intValid is 0, and intCode and intLevel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postValid | input | 1 | Post request strobe |
| postType | input | 3 | Source type to post |
| postIdx | input | 6 | Bit index to set |
| clrValid | input | 1 | Clear request strobe |
| clrType | input | 3 | Source type to clear |
| clrIdx | input | 6 | Bit index to clear |
| hprivMode | input | 1 | Core runs in hyperprivileged mode |
| intEnable | input | 1 | Core interrupt-enable flag |
| intValid | output | 1 | An eligible interrupt is selected |
| intCode | output | 3 | Code of the selected source |
| intLevel | output | 4 | Software-interrupt level, 0 otherwise |
| pendSummary | output | 7 | One pending bit per source type |
| errStrobe | output | 1 | Pulse after a request with an invalid type |

## Verification
The bench builds the block with its default of seven source types carried on a 3-bit type field. This leaves code 7 free, so the dropped-request path and the error strobe can be driven through the normal ports. The full 64-bit vector width lets the bench place software bits above 16, which reaches the level-1 fallback, and place bits exactly at 0, 15 and 16, which reach the special case and the top of the scan. Directed sequences walk each priority ladder under both flag settings. A randomized sequence then compares the winner and level against a reference model kept in the bench.

// File: rtl/irq_pend_sel_pkg.sv
package irq_pend_sel_pkg;
  localparam int TYPE_W  = 3;
  localparam int VEC_W   = 64;
  localparam int IDX_W   = $clog2(VEC_W);
  localparam int LEVEL_W = 4;
  localparam int SOFT_LO = 17;

  localparam int SRC_TIMER  = 0;
  localparam int SRC_VECTOR = 1;
  localparam int SRC_TLZ    = 2;
  localparam int SRC_CPUM   = 3;
  localparam int SRC_DEVM   = 4;
  localparam int SRC_SOFT   = 5;
  localparam int SRC_RERR   = 6;

  typedef struct packed {
    logic              postEn;
    logic [TYPE_W-1:0] postType;
    logic [IDX_W-1:0]  postIdx;
    logic              clrEn;
    logic [TYPE_W-1:0] clrType;
    logic [IDX_W-1:0]  clrIdx;
  } updStrobe_t;

  // Level from the low bits of the software vector.
  function automatic logic [LEVEL_W-1:0] softLevelOf(input logic [SOFT_LO-1:0] v);
    logic [LEVEL_W-1:0] lvl;
    lvl = LEVEL_W'(1);
    for (int l = 1; l < 16; l++) begin
      if (v[l]) lvl = LEVEL_W'(l);
    end
    if (v[0] || v[16]) lvl = LEVEL_W'(14);
    return lvl;
  endfunction
endpackage

// File: rtl/irq_pend_sel_ctrl.sv
module irq_pend_sel_ctrl
  import irq_pend_sel_pkg::*;
#(
  parameter int NUM_TYPES = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              postValid,
  input  logic [TYPE_W-1:0] postType,
  input  logic [IDX_W-1:0]  postIdx,
  input  logic              clrValid,
  input  logic [TYPE_W-1:0] clrType,
  input  logic [IDX_W-1:0]  clrIdx,
  output updStrobe_t        stb,
  output logic              errStrobe
);
  localparam logic [TYPE_W-1:0] LAST_TYPE = TYPE_W'(NUM_TYPES - 1);

  logic postOk, clrOk, badReq;

  always_comb begin
    postOk       = postType <= LAST_TYPE;
    clrOk        = clrType <= LAST_TYPE;
    badReq       = (postValid && !postOk) || (clrValid && !clrOk);
    stb.postEn   = postValid && postOk;
    stb.postType = postType;
    stb.postIdx  = postIdx;
    stb.clrEn    = clrValid && clrOk;
    stb.clrType  = clrType;
    stb.clrIdx   = clrIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errStrobe <= 1'b0;
    else       errStrobe <= badReq;
  end
endmodule

// File: rtl/irq_pend_sel_dp.sv
module irq_pend_sel_dp
  import irq_pend_sel_pkg::*;
#(
  parameter int NUM_TYPES = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  updStrobe_t           stb,
  output logic [NUM_TYPES-1:0] summary,
  output logic [LEVEL_W-1:0]   softLevel
);
  logic [NUM_TYPES-1:0][VEC_W-1:0] vecQ, nextVec;
  logic [NUM_TYPES-1:0]            postHit, clrHit;
  logic [NUM_TYPES-1:0]            summaryQ;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_hit
    assign postHit[t] = stb.postEn && (stb.postType == TYPE_W'(t));
    assign clrHit[t]  = stb.clrEn && (stb.clrType == TYPE_W'(t));
  end

  // Clear applied after set, so a same-bit collision ends cleared.
  always_comb begin
    for (int t = 0; t < NUM_TYPES; t++) begin
      nextVec[t] = vecQ[t];
      if (postHit[t]) nextVec[t][stb.postIdx] = 1'b1;
      if (clrHit[t])  nextVec[t][stb.clrIdx]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ     <= '0;
      summaryQ <= '0;
    end else begin
      vecQ <= nextVec;
      for (int t = 0; t < NUM_TYPES; t++) begin
        if (clrHit[t] && nextVec[t] == '0) summaryQ[t] <= 1'b0;
        else if (postHit[t])               summaryQ[t] <= 1'b1;
      end
    end
  end

  assign summary   = summaryQ;
  assign softLevel = softLevelOf(vecQ[SRC_SOFT][SOFT_LO-1:0]);
endmodule

// File: rtl/irq_pend_sel_arb.sv
module irq_pend_sel_arb
  import irq_pend_sel_pkg::*;
#(
  parameter int NUM_TYPES = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TYPES-1:0] summary,
  input  logic [LEVEL_W-1:0]   softLevel,
  input  logic                 hprivMode,
  input  logic                 intEnable,
  output logic                 intValid,
  output logic [TYPE_W-1:0]    intCode,
  output logic [LEVEL_W-1:0]   intLevel
);
  logic              winValid;
  logic [TYPE_W-1:0] winCode;

  always_comb begin
    winValid = 1'b1;
    winCode  = '0;
    if (hprivMode) begin
      if      (summary[SRC_TIMER])  winCode = TYPE_W'(SRC_TIMER);
      else if (summary[SRC_VECTOR]) winCode = TYPE_W'(SRC_VECTOR);
      else                          winValid = 1'b0;
    end else begin
      if      (summary[SRC_TLZ])                 winCode = TYPE_W'(SRC_TLZ);
      else if (summary[SRC_TIMER])               winCode = TYPE_W'(SRC_TIMER);
      else if (summary[SRC_VECTOR])              winCode = TYPE_W'(SRC_VECTOR);
      else if (intEnable && summary[SRC_CPUM])   winCode = TYPE_W'(SRC_CPUM);
      else if (intEnable && summary[SRC_DEVM])   winCode = TYPE_W'(SRC_DEVM);
      else if (intEnable && summary[SRC_SOFT])   winCode = TYPE_W'(SRC_SOFT);
      else if (intEnable && summary[SRC_RERR])   winCode = TYPE_W'(SRC_RERR);
      else                                       winValid = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intValid <= 1'b0;
      intCode  <= '0;
      intLevel <= '0;
    end else begin
      intValid <= winValid;
      intCode  <= winCode;
      intLevel <= (winValid && winCode == TYPE_W'(SRC_SOFT)) ? softLevel : '0;
    end
  end
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_pend_sel_pkg::*;
#(
  parameter int NUM_TYPES = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 postValid,
  input  logic [TYPE_W-1:0]    postType,
  input  logic [IDX_W-1:0]     postIdx,
  input  logic                 clrValid,
  input  logic [TYPE_W-1:0]    clrType,
  input  logic [IDX_W-1:0]     clrIdx,
  input  logic                 hprivMode,
  input  logic                 intEnable,
  output logic                 intValid,
  output logic [TYPE_W-1:0]    intCode,
  output logic [LEVEL_W-1:0]   intLevel,
  output logic [NUM_TYPES-1:0] pendSummary,
  output logic                 errStrobe
);
  updStrobe_t         stb;
  logic [LEVEL_W-1:0] softLevel;

  irq_pend_sel_ctrl #(.NUM_TYPES(NUM_TYPES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postType(postType), .postIdx(postIdx),
    .clrValid(clrValid), .clrType(clrType), .clrIdx(clrIdx),
    .stb(stb), .errStrobe(errStrobe)
  );

  irq_pend_sel_dp #(.NUM_TYPES(NUM_TYPES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .summary(pendSummary), .softLevel(softLevel)
  );

  irq_pend_sel_arb #(.NUM_TYPES(NUM_TYPES)) u_arb (
    .clk(clk), .rstN(rstN), .summary(pendSummary), .softLevel(softLevel),
    .hprivMode(hprivMode), .intEnable(intEnable),
    .intValid(intValid), .intCode(intCode), .intLevel(intLevel)
  );
endmodule

// File: rtl/irq_pend_sel_chk.sv
module irq_pend_sel_chk
  import irq_pend_sel_pkg::*;
#(
  parameter int NUM_TYPES = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 postValid,
  input logic [TYPE_W-1:0]    postType,
  input logic [IDX_W-1:0]     postIdx,
  input logic                 clrValid,
  input logic [TYPE_W-1:0]    clrType,
  input logic [IDX_W-1:0]     clrIdx,
  input logic                 hprivMode,
  input logic                 intEnable,
  input logic                 intValid,
  input logic [TYPE_W-1:0]    intCode,
  input logic [LEVEL_W-1:0]   intLevel,
  input logic [NUM_TYPES-1:0] pendSummary,
  input logic                 errStrobe
);
  localparam logic [TYPE_W-1:0] LAST_TYPE = TYPE_W'(NUM_TYPES - 1);

  logic postGood, sameBit;
  assign postGood = postValid && postType <= LAST_TYPE;
  assign sameBit  = clrValid && clrType == postType && clrIdx == postIdx;

  p_post_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (postGood && !sameBit) |=> pendSummary[$past(postType)]);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (postGood && sameBit && !pendSummary[postType]) |=> !pendSummary[$past(postType)]);

  p_bad_type_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && postType > LAST_TYPE) |=> errStrobe);

  p_hpriv_timer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hprivMode && pendSummary[SRC_TIMER]) |=> (intValid && intCode == TYPE_W'(SRC_TIMER)));

  p_tlz_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!hprivMode && pendSummary[SRC_TLZ]) |=> (intValid && intCode == TYPE_W'(SRC_TLZ)));

  p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hprivMode || !intEnable) |=> !(intValid && intCode >= TYPE_W'(SRC_CPUM)));

  p_level_only_soft_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intCode != TYPE_W'(SRC_SOFT)) |-> intLevel == '0);

  p_idle_outputs_r10: assert property (@(posedge clk) disable iff (!rstN)
    !intValid |-> (intCode == '0 && intLevel == '0));

  p_idle_when_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pendSummary == '0) |=> !intValid);
endmodule

bind irq_pend_sel irq_pend_sel_chk #(.NUM_TYPES(NUM_TYPES)) u_chk (
  .clk(clk), .rstN(rstN),
  .postValid(postValid), .postType(postType), .postIdx(postIdx),
  .clrValid(clrValid), .clrType(clrType), .clrIdx(clrIdx),
  .hprivMode(hprivMode), .intEnable(intEnable),
  .intValid(intValid), .intCode(intCode), .intLevel(intLevel),
  .pendSummary(pendSummary), .errStrobe(errStrobe)
);

// File: tb/irq_pend_sel_bench.sv
`timescale 1ns/1ps
module irq_pend_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       postValid = 1'b0, clrValid = 1'b0;
  logic [2:0] postType = '0, clrType = '0;
  logic [5:0] postIdx = '0, clrIdx = '0;
  logic       hprivMode = 1'b0, intEnable = 1'b0;
  logic       intValid;
  logic [2:0] intCode;
  logic [3:0] intLevel;
  logic [6:0] pendSummary;
  logic       errStrobe;

  int checks = 0;
  int failures = 0;
  logic [63:0] mVec [7];

  always #2.5 clk = ~clk;

  irq_pend_sel u_irq_pend_sel (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postType(postType), .postIdx(postIdx),
    .clrValid(clrValid), .clrType(clrType), .clrIdx(clrIdx),
    .hprivMode(hprivMode), .intEnable(intEnable),
    .intValid(intValid), .intCode(intCode), .intLevel(intLevel),
    .pendSummary(pendSummary), .errStrobe(errStrobe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] refSummary();
    logic [6:0] s;
    for (int t = 0; t < 7; t++) s[t] = (mVec[t] != 64'd0);
    return s;
  endfunction

  function automatic int refLevel(input logic [63:0] v);
    if (v[0] || v[16]) return 14;
    for (int l = 15; l >= 1; l--) if (v[l]) return l;
    return 1;
  endfunction

  // Returns -1 when nothing eligible.
  function automatic int refWinner(input logic h, input logic e);
    logic [6:0] s;
    int order [7];
    int n;
    s = refSummary();
    if (h) begin
      order[0] = 0; order[1] = 1; n = 2;
    end else begin
      order[0] = 2; order[1] = 0; order[2] = 1; n = 3;
      if (e) begin
        order[3] = 3; order[4] = 4; order[5] = 5; order[6] = 6; n = 7;
      end
    end
    for (int k = 0; k < n; k++) if (s[order[k]]) return order[k];
    return -1;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    postValid = 1'b0; clrValid = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    for (int t = 0; t < 7; t++) mVec[t] = 64'd0;
  endtask

  // Drive one request cycle; returns at the negedge after the update edge.
  task automatic applyOp(input logic pv, input logic [2:0] pt, input logic [5:0] pi,
                         input logic cv, input logic [2:0] ct, input logic [5:0] ci);
    @(negedge clk);
    postValid = pv; postType = pt; postIdx = pi;
    clrValid = cv; clrType = ct; clrIdx = ci;
    if (pv && pt < 7) mVec[pt][pi] = 1'b1;
    if (cv && ct < 7) mVec[ct][ci] = 1'b0;
    @(negedge clk);
    postValid = 1'b0; clrValid = 1'b0;
  endtask

  task automatic post(input int t, input int i);
    applyOp(1'b1, 3'(t), 6'(i), 1'b0, 3'd0, 6'd0);
  endtask

  task automatic clr(input int t, input int i);
    applyOp(1'b0, 3'd0, 6'd0, 1'b1, 3'(t), 6'(i));
  endtask

  task automatic setMode(input logic h, input logic e);
    @(negedge clk);
    hprivMode = h; intEnable = e;
  endtask

  // Waits for the output register and compares against the model.
  task automatic checkSel(input string tag);
    int w;
    int expLvl;
    @(negedge clk);
    w = refWinner(hprivMode, intEnable);
    expLvl = (w == 5) ? refLevel(mVec[5]) : 0;
    check(intValid == (w >= 0), {tag, " valid"}, int'(intValid), int'(w >= 0));
    check(int'(intCode) == ((w >= 0) ? w : 0), {tag, " code"}, int'(intCode), (w >= 0) ? w : 0);
    check(int'(intLevel) == expLvl, {tag, " level"}, int'(intLevel), expLvl);
  endtask

  task automatic testReset();
    doReset();
    check(intValid == 1'b0 && intCode == 3'd0 && intLevel == 4'd0, "R1 outputs", int'(intValid), 0);
    check(pendSummary == 7'd0, "R1 summary", int'(pendSummary), 0);
    check(errStrobe == 1'b0, "R1 errStrobe", int'(errStrobe), 0);
  endtask

  task automatic testPostClear();
    doReset();
    setMode(1'b0, 1'b1);
    post(3, 10);
    check(pendSummary == 7'b0001000, "R2 summary after post", int'(pendSummary), 8);
    checkSel("R2 select");
    post(3, 63);
    clr(3, 10);
    check(pendSummary[3] == 1'b1, "R3 summary kept", int'(pendSummary[3]), 1);
    clr(3, 63);
    check(pendSummary[3] == 1'b0, "R3 summary dropped", int'(pendSummary[3]), 0);
    checkSel("R10 empty");
  endtask

  task automatic testCollision();
    doReset();
    setMode(1'b0, 1'b1);
    applyOp(1'b1, 3'd4, 6'd7, 1'b1, 3'd4, 6'd7);
    check(pendSummary[4] == 1'b0, "R4 clear wins", int'(pendSummary[4]), 0);
    checkSel("R4 clear wins select");
    applyOp(1'b1, 3'd4, 6'd8, 1'b1, 3'd4, 6'd9);
    check(pendSummary[4] == 1'b1, "R4 both apply", int'(pendSummary[4]), 1);
    clr(4, 8);
    check(pendSummary[4] == 1'b0, "R4 bit 9 never set", int'(pendSummary[4]), 0);
  endtask

  task automatic testBadType();
    doReset();
    setMode(1'b0, 1'b1);
    post(6, 2);
    checkSel("R5 before");
    applyOp(1'b1, 3'd7, 6'd2, 1'b0, 3'd0, 6'd0);
    check(errStrobe == 1'b1, "R5 err post", int'(errStrobe), 1);
    check(pendSummary == 7'b1000000, "R5 summary post", int'(pendSummary), 64);
    @(negedge clk);
    check(errStrobe == 1'b0, "R5 err one cycle", int'(errStrobe), 0);
    applyOp(1'b0, 3'd0, 6'd0, 1'b1, 3'd7, 6'd2);
    check(errStrobe == 1'b1, "R5 err clear", int'(errStrobe), 1);
    check(pendSummary == 7'b1000000, "R5 summary clear", int'(pendSummary), 64);
    checkSel("R5 after");
  endtask

  task automatic testLadder();
    doReset();
    for (int t = 0; t < 7; t++) post(t, 20 + t);
    setMode(1'b1, 1'b1); checkSel("R6 timer first");
    setMode(1'b0, 1'b0); checkSel("R7 tlz first");
    clr(2, 22);
    checkSel("R7 timer second");
    clr(0, 20);
    setMode(1'b1, 1'b0); checkSel("R6 vector second");
    setMode(1'b0, 1'b1); checkSel("R7 vector third");
    clr(1, 21);
    setMode(1'b1, 1'b1); checkSel("R6 ignores rest");
    setMode(1'b0, 1'b0); checkSel("R8 enable off");
    setMode(1'b0, 1'b1); checkSel("R8 cpu mondo");
    clr(3, 23); checkSel("R8 dev mondo");
    clr(4, 24); checkSel("R8 soft");
    clr(5, 25); checkSel("R8 resumable");
  endtask

  task automatic testLevels();
    int bits [6] = '{0, 16, 9, 40, 15, 3};
    int exps [6] = '{14, 14, 9, 1, 15, 3};
    doReset();
    setMode(1'b0, 1'b1);
    for (int k = 0; k < 6; k++) begin
      post(5, bits[k]);
      @(negedge clk);
      check(int'(intLevel) == exps[k], "R9 single bit level", int'(intLevel), exps[k]);
      clr(5, bits[k]);
    end
    post(5, 3); post(5, 12); post(5, 50);
    checkSel("R9 highest of several");
    post(5, 16);
    checkSel("R9 special wins over 12");
  endtask

  task automatic testRandom();
    logic pv, cv, h, e;
    logic [2:0] pt, ct;
    logic [5:0] pi, ci;
    doReset();
    for (int n = 0; n < 300; n++) begin
      pv = 1'b1;
      cv = ($urandom % 3) == 0;
      pt = 3'($urandom % 8);
      pi = 6'($urandom % 64);
      ct = (($urandom % 2) == 0) ? pt : 3'($urandom % 8);
      ci = (($urandom % 2) == 0) ? pi : 6'($urandom % 24);
      h = ($urandom % 4) == 0;
      e = ($urandom % 3) != 0;
      setMode(h, e);
      applyOp(pv, pt, pi, cv, ct, ci);
      check(pendSummary == refSummary(), "R3 random summary", int'(pendSummary), int'(refSummary()));
      checkSel("R8 random select");
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int t = 0; t < 7; t++) mVec[t] = 64'd0;
    testReset();
    testPostClear();
    testCollision();
    testBadType();
    testLadder();
    testLevels();
    testRandom();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule